// File: doc/BRIEF.md
# Serial CRC Engine with Run-Time Polynomial Choice

This block computes a cyclic redundancy check one bit per clock, taking the most significant bit first. One engine serves four standard generator polynomials of degree 12, 16 and 32. The polynomial and the direction of use are chosen on a start pulse and held until the next one. All arithmetic is modulo 2, so every subtraction in the long division is an XOR.

In generate mode the engine divides the data bits, shifted up by the degree r, by the chosen polynomial. When the bit marked last has been taken in, the r-bit remainder is shifted out after the data as the frame check sequence, highest bit first. In check mode the whole received frame, data followed by its check sequence, goes through the same division. A pass flag reports whether the remainder came out as zero. A nonzero remainder means the frame is corrupted.

The remainder register is 32 bits wide. For a polynomial of degree r only its low r bits are used, and the feedback comes from bit r-1. Bit reflection, preset values and an output inversion are not part of this engine.

Top module: `crc_serial_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, fcs_valid and crc_ok are both low.
- R2: In generate mode, starting the cycle after the last data bit is accepted, fcs_valid is high for exactly r consecutive cycles. fcs_bit carries the remainder of D·2^r divided by P, highest bit first.
- R3: The poly_sel encodings are: 0 selects X^12+X^11+X^3+X^2+X+1 (r=12); 1 selects X^16+X^15+X^2+1 (r=16); 2 selects X^16+X^12+X^5+1 (r=16); 3 selects X^32+X^26+X^23+X^22+X^16+X^12+X^11+X^10+X^8+X^7+X^5+X^4+X^2+X+1 (r=32).
- R4: In check mode, in the cycle after the final frame bit, crc_ok is high if the frame divides exactly by P. crc_ok then holds its value until the next start.
- R5: In check mode, a frame with any single flipped bit leaves crc_ok low.
- R6: start clears the remainder and drives crc_ok and fcs_valid low in the next cycle. poly_sel is sampled only on start, so changes between starts have no effect.
- R7: While the check sequence is being shifted out, bit_valid, bit_in and last are ignored, and the emitted sequence is unchanged.
- R8: Cycles with bit_valid low leave the division unaffected, whatever bit_in carries.
- R9: A start during emission ends fcs_valid in the next cycle.
- R10: In generate mode crc_ok stays low. The mode encoding is 0 for generate and 1 for check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame: clears state, samples mode and poly_sel |
| mode | input | 1 | 0 generate, 1 check |
| poly_sel | input | 2 | Polynomial choice (see R3) |
| bit_valid | input | 1 | bit_in carries a frame bit this cycle |
| bit_in | input | 1 | Serial frame bit, MSB first |
| last | input | 1 | Marks the final bit of data (generate) or frame (check) |
| fcs_bit | output | 1 | Serial check-sequence bit, MSB first |
| fcs_valid | output | 1 | fcs_bit is valid |
| crc_ok | output | 1 | Zero remainder on the checked frame |

## Verification
Each polynomial runs on data of several shapes: one bit, a short 5-bit pattern, odd byte counts, all ones, and all zeros. The all-zero frame must yield a zero sequence, and the other frames separate the tap patterns of the two degree-16 polynomials. Each generated sequence is fed back in check mode to show the pass case. The same frame with one middle bit flipped separates real division from a check that passes regardless of the bits. Directed frames add idle gaps carrying inverted noise, poly_sel changing after start, input noise during emission, and an abort by start. These show that only qualified bits and the sampled polynomial affect the result.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    localparam int CRC_W = 32;
    localparam int DEG_W = 6;

    typedef enum logic [1:0] {
        POLY_C12   = 2'd0,
        POLY_C16   = 2'd1,
        POLY_CCITT = 2'd2,
        POLY_C32   = 2'd3
    } poly_id_e;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EMIT = 2'd2
    } ctrl_state_e;

    // taps: polynomial without its top term; keep: low-r mask
    typedef struct packed {
        logic [CRC_W-1:0] taps;
        logic [CRC_W-1:0] keep;
        logic [DEG_W-1:0] degree;
    } poly_info_t;

    typedef struct packed {
        logic clear;
        logic step;
        logic shift;
        logic din;
    } core_cmd_t;

    function automatic logic [CRC_W-1:0] low_mask(input logic [DEG_W-1:0] deg);
        logic [CRC_W:0] one;
        logic [CRC_W:0] full;
        one  = (CRC_W+1)'(1);
        full = (one << deg) - one;
        return full[CRC_W-1:0];
    endfunction

    function automatic poly_info_t poly_lookup(input poly_id_e id);
        poly_info_t p;
        case (id)
            POLY_C12: begin
                p.taps   = CRC_W'(32'h0000_080F);
                p.degree = DEG_W'(12);
            end
            POLY_C16: begin
                p.taps   = CRC_W'(32'h0000_8005);
                p.degree = DEG_W'(16);
            end
            POLY_CCITT: begin
                p.taps   = CRC_W'(32'h0000_1021);
                p.degree = DEG_W'(16);
            end
            default: begin
                p.taps   = CRC_W'(32'h04C1_1DB7);
                p.degree = DEG_W'(32);
            end
        endcase
        p.keep = low_mask(p.degree);
        return p;
    endfunction

endpackage

// File: rtl/crc_poly_rom.sv
module crc_poly_rom
    import crc_serial_pkg::*;
(
    input  poly_id_e   sel,
    output poly_info_t info
);
    always_comb begin
        info = poly_lookup(sel);
    end
endmodule

// File: rtl/crc_div_core.sv
module crc_div_core
    import crc_serial_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic       clk,
    input  logic       rst,
    input  core_cmd_t  cmd,
    input  poly_info_t info,
    output logic       msb,
    output logic       step_zero
);
    logic [W-1:0] rem_q;
    logic [W-1:0] step_nxt;
    logic [W-1:0] shift_nxt;
    logic [W-1:0] top_sel;
    logic         fb;

    // one-hot marker of bit r-1 within the live window
    assign top_sel = info.keep[W-1:0] ^ (info.keep[W-1:0] >> 1);
    assign msb     = |(rem_q & top_sel);
    assign fb      = msb ^ cmd.din;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign step_nxt[i]  = fb & info.taps[i] & info.keep[i];
            assign shift_nxt[i] = 1'b0;
        end else begin : g_up
            assign step_nxt[i]  = (rem_q[i-1] ^ (fb & info.taps[i])) & info.keep[i];
            assign shift_nxt[i] = rem_q[i-1] & info.keep[i];
        end
    end

    assign step_zero = ~|step_nxt;

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            rem_q <= '0;
        end else if (cmd.step) begin
            rem_q <= step_nxt;
        end else if (cmd.shift) begin
            rem_q <= shift_nxt;
        end
    end
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
    import crc_serial_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  crc_mode_e        mode,
    input  poly_id_e         poly_sel,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             last,
    input  logic [DEG_W-1:0] degree,
    input  logic             step_zero,
    output poly_id_e         sel_q,
    output core_cmd_t        cmd,
    output logic             fcs_valid,
    output logic             crc_ok
);
    ctrl_state_e      state_q;
    crc_mode_e        mode_q;
    logic [DEG_W-1:0] cnt_q;
    logic             final_bit;

    assign final_bit = (state_q == ST_RUN) && bit_valid && last;

    always_comb begin
        cmd.clear = start;
        cmd.step  = !start && (state_q == ST_RUN) && bit_valid;
        cmd.shift = !start && (state_q == ST_EMIT);
        cmd.din   = bit_in;
    end

    assign fcs_valid = (state_q == ST_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_GEN;
            sel_q   <= POLY_C12;
            cnt_q   <= '0;
            crc_ok  <= 1'b0;
        end else if (start) begin
            state_q <= ST_RUN;
            mode_q  <= mode;
            sel_q   <= poly_sel;
            cnt_q   <= '0;
            crc_ok  <= 1'b0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (final_bit) begin
                        if (mode_q == MODE_CHK) begin
                            crc_ok  <= step_zero;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q   <= degree - DEG_W'(1);
                            state_q <= ST_EMIT;
                        end
                    end
                end
                ST_EMIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - DEG_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode,
    input  logic [1:0] poly_sel,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       last,
    output logic       fcs_bit,
    output logic       fcs_valid,
    output logic       crc_ok
);
    poly_id_e   sel_q;
    poly_info_t info;
    core_cmd_t  cmd;
    logic       core_msb;
    logic       core_zero;

    crc_poly_rom u_rom (
        .sel  (sel_q),
        .info (info)
    );

    crc_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (crc_mode_e'(mode)),
        .poly_sel  (poly_id_e'(poly_sel)),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .last      (last),
        .degree    (info.degree),
        .step_zero (core_zero),
        .sel_q     (sel_q),
        .cmd       (cmd),
        .fcs_valid (fcs_valid),
        .crc_ok    (crc_ok)
    );

    crc_div_core #(.W(CRC_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .info      (info),
        .msb       (core_msb),
        .step_zero (core_zero)
    );

    assign fcs_bit = fcs_valid & core_msb;
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk
    import crc_serial_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       mode,
    input logic [1:0] poly_sel,
    input logic       fcs_valid,
    input logic       crc_ok
);
    logic             mode_seen;
    logic [DEG_W-1:0] deg_seen;
    logic [DEG_W:0]   run_len;
    poly_info_t       pi;

    always_comb pi = poly_lookup(poly_id_e'(poly_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_seen <= 1'b0;
            deg_seen  <= DEG_W'(12);
            run_len   <= '0;
        end else begin
            if (start) begin
                mode_seen <= mode;
                deg_seen  <= pi.degree;
            end
            run_len <= fcs_valid ? run_len + (DEG_W+1)'(1) : '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fcs_valid && !crc_ok));

    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!crc_ok && !fcs_valid));

    // R4
    ok_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (crc_ok && !start) |=> crc_ok);

    // R10
    gen_no_ok_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_seen |-> !crc_ok);

    // R2
    fcs_length_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(fcs_valid) && !$past(start)) |-> (run_len == {1'b0, deg_seen}));
endmodule

bind crc_serial_engine crc_serial_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .poly_sel  (poly_sel),
    .fcs_valid (fcs_valid),
    .crc_ok    (crc_ok)
);

// File: tb/crc_serial_engine_tb_top.sv
module crc_serial_engine_tb_top;

    typedef struct packed {
        logic [1:0]  sel;
        logic [5:0]  len;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 6'd8,  32'h0000_00A5},
        '{2'd1, 6'd16, 32'h0000_1234},
        '{2'd2, 6'd24, 32'h0031_3233},
        '{2'd3, 6'd32, 32'hDEAD_BEEF},
        '{2'd0, 6'd1,  32'h0000_0001},
        '{2'd3, 6'd5,  32'h0000_0017},
        '{2'd2, 6'd32, 32'h0000_0000},
        '{2'd1, 6'd32, 32'hFFFF_FFFF}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] poly_sel = 2'd0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       last = 1'b0;
    logic       fcs_bit;
    logic       fcs_valid;
    logic       crc_ok;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    crc_serial_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .poly_sel  (poly_sel),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .last      (last),
        .fcs_bit   (fcs_bit),
        .fcs_valid (fcs_valid),
        .crc_ok    (crc_ok)
    );

    function automatic int deg_of(input logic [1:0] s);
        case (s)
            2'd0: return 12;
            2'd3: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic logic [32:0] full_poly(input logic [1:0] s);
        case (s)
            2'd0: return 33'h0_0000_180F;
            2'd1: return 33'h0_0001_8005;
            2'd2: return 33'h0_0001_1021;
            default: return 33'h1_04C1_1DB7;
        endcase
    endfunction

    // long division of D * 2^r by the full polynomial
    function automatic logic [31:0] ref_rem(input logic [31:0] d, input int len, input logic [1:0] s);
        logic [63:0] dv;
        int r;
        r  = deg_of(s);
        dv = 64'(d) << r;
        for (int i = len + r - 1; i >= r; i--) begin
            if (dv[i]) dv = dv ^ (64'(full_poly(s)) << (i - r));
        end
        return dv[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic m, input logic [1:0] s);
        start    = 1'b1;
        mode     = m;
        poly_sel = s;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_bits(input logic [63:0] d, input int len, input bit stall);
        for (int i = len - 1; i >= 0; i--) begin
            if (stall) begin
                bit_valid = 1'b0;
                bit_in    = ~d[i];
                last      = 1'b1;
                @(negedge clk);
            end
            bit_valid = 1'b1;
            bit_in    = d[i];
            last      = (i == 0);
            @(negedge clk);
        end
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        last      = 1'b0;
    endtask

    task automatic collect(input bit noise, output logic [31:0] f, output int n);
        f = '0;
        n = 0;
        while (fcs_valid && n < 40) begin
            f = {f[30:0], fcs_bit};
            n++;
            if (noise) begin
                bit_valid = 1'b1;
                bit_in    = n[0];
                last      = 1'b1;
            end
            @(negedge clk);
        end
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        last      = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] f;
        logic [31:0] e;
        int n;
        int r;
        logic [63:0] frame;

        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check(!fcs_valid && !crc_ok, "R1 in reset", {fcs_valid, crc_ok}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!fcs_valid && !crc_ok, "R1 after reset", {fcs_valid, crc_ok}, 0);

        for (int v = 0; v < NVEC; v++) begin
            r = deg_of(VECS[v].sel);
            e = ref_rem(VECS[v].data, int'(VECS[v].len), VECS[v].sel);
            // R2 R3: generate
            do_start(1'b0, VECS[v].sel);
            send_bits(64'(VECS[v].data), int'(VECS[v].len), 1'b0);
            collect(1'b0, f, n);
            check(f == e, "R2/R3 fcs value", f, e);
            check(n == r, "R2 fcs length", n, r);
            // R4: check the intact frame
            frame = (64'(VECS[v].data) << r) | 64'(e);
            do_start(1'b1, VECS[v].sel);
            send_bits(frame, int'(VECS[v].len) + r, 1'b0);
            check(crc_ok == 1'b1, "R4 intact frame", crc_ok, 1);
            // R5: one bit flipped
            frame[(int'(VECS[v].len) + r) / 2] = ~frame[(int'(VECS[v].len) + r) / 2];
            do_start(1'b1, VECS[v].sel);
            send_bits(frame, int'(VECS[v].len) + r, 1'b0);
            check(crc_ok == 1'b0, "R5 corrupted frame", crc_ok, 0);
        end

        // R4: pass flag holds over idle cycles; R6: start clears it
        r = 16;
        e = ref_rem(32'h1234, 16, 2'd1);
        do_start(1'b1, 2'd1);
        send_bits((64'h1234 << r) | 64'(e), 32, 1'b0);
        bit_valid = 1'b1;
        bit_in    = 1'b1;
        repeat (4) @(negedge clk);
        bit_valid = 1'b0;
        check(crc_ok == 1'b1, "R4 hold", crc_ok, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(crc_ok == 1'b0, "R6 start clears ok", crc_ok, 0);

        // R6: poly_sel change after start ignored
        e = ref_rem(32'hBEEF, 16, 2'd1);
        do_start(1'b0, 2'd1);
        poly_sel = 2'd3;
        send_bits(64'hBEEF, 16, 1'b0);
        collect(1'b0, f, n);
        check(f == e && n == 16, "R6 sel sampled at start", {n[31:0], f}, {32'd16, e});
        // R10: generate mode leaves crc_ok low
        check(crc_ok == 1'b0, "R10 gen crc_ok low", crc_ok, 0);

        // R7: input noise during emission
        e = ref_rem(32'h1234, 16, 2'd2);
        do_start(1'b0, 2'd2);
        send_bits(64'h1234, 16, 1'b0);
        collect(1'b1, f, n);
        check(f == e && n == 16, "R7 noise during emission", {n[31:0], f}, {32'd16, e});

        // R8: idle gaps with inverted bits
        e = ref_rem(32'hDEADBEEF, 32, 2'd3);
        do_start(1'b0, 2'd3);
        send_bits(64'hDEADBEEF, 32, 1'b1);
        collect(1'b0, f, n);
        check(f == e && n == 32, "R8 stall gaps", {n[31:0], f}, {32'd32, e});

        // R9: start aborts emission
        do_start(1'b0, 2'd3);
        send_bits(64'hA5, 8, 1'b0);
        repeat (3) @(negedge clk);
        check(fcs_valid == 1'b1, "R9 emitting before abort", fcs_valid, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(fcs_valid == 1'b0, "R9 abort by start", fcs_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule